// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog peripheral on a simple register bus with a word address, a write enable, write data and combinational read data. Software configures it through two key-protected registers: a mode register (enable, reset-output enable, interrupt enable, reset pulse length) and a counter control register (coarse reload value and prescaler select). A write to either register is accepted only when bits [23:12] of the write data carry the key for that register. All other writes to those registers are silently dropped.

Once enabled, a down counter is loaded from the coarse reload field, scaled by a power of two with all low bits set. It then counts one step per prescaler tick. Software keeps the system alive by writing one exact magic word to the restart register, which reloads the counter. If the counter runs down to zero, the block sets a status flag. It can also drive a reset pulse of a programmed length and an interrupt level that stays high until the next valid restart.

Top module: `keyed_wdog`

## Requirements
- R1: After reset both outputs are low, and reads of the four registers return zero. The registers sit at word offsets: mode 0x0, counter control 0x4, restart 0x8, status 0xC. An access with address bits [1:0] not zero is ignored and reads as zero.
- R2: A write to the mode register changes nothing unless write data bits [23:12] equal 0xABC.
- R3: Mode fields are bit 0 enable, bit 1 reset-output enable, bit 2 interrupt enable and bits [5:4] pulse-length code. A mode read returns these fields with every other bit, the key included, as zero.
- R4: A write to the counter control register is accepted only when bits [23:12] equal 0x920. Its fields are the reload value in bits [13:2] and the prescaler select in bits [1:0]. A read returns them with every other bit as zero.
- R5: Prescaler select 0, 1, 2 and 3 give one tick every 2^DIV0_LOG, 2^DIV1_LOG, 2^DIV2_LOG and 2^DIV3_LOG cycles. The defaults are 8, 64, 512 and 4096.
- R6: The counter loads (reload << COARSE_SHIFT) | (2^COARSE_SHIFT - 1) in two cases: on a mode write that sets enable while the block is disabled, and on a valid restart. The prescaler phase returns to zero at the same time, so the first expiry comes exactly load × divisor cycles after the loading write.
- R7: Only a write of exactly 0x00001999 to the restart register counts as a restart. Any other value leaves the counter, status and outputs untouched.
- R8: On the tick that takes the count from 1 to 0, status bit 0 is set. The count then holds at zero until the next reload.
- R9: If the reset output is enabled at expiry, the reset output goes high for 2, 4, 8 or 16 cycles for pulse-length codes 0, 1, 2 and 3.
- R10: If the interrupt is enabled at expiry, the interrupt output stays high until a valid restart. That restart also clears status bit 0.
- R11: While enable is clear, the count and the prescaler do not advance and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| wdt_rst_o | output | 1 | Reset pulse on expiry |
| wdt_irq_o | output | 1 | Interrupt level on expiry |

## Verification
The bench builds the block with COARSE_SHIFT=2 and divider logs 1, 2, 3 and 4. A reload value of 1 then expires after 7 ticks, which is 14 to 112 cycles depending on the prescaler. With these values every prescaler select and every pulse-length code can be run to expiry many times within a short run. The reload scaling, the prescaler phase reset and the pulse widths are all measured in exact cycle counts.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;

    localparam int          CRV_W         = 12;
    localparam logic [11:0] MODE_KEY      = 12'hABC;
    localparam logic [11:0] CCR_KEY       = 12'h920;
    localparam logic [31:0] RESTART_MAGIC = 32'h0000_1999;

    typedef enum logic [1:0] {
        REG_MODE = 2'd0,
        REG_CCR  = 2'd1,
        REG_KICK = 2'd2,
        REG_STAT = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [1:0] len;
        logic       irq_en;
        logic       rst_en;
        logic       en;
    } mode_t;

    typedef struct packed {
        logic [CRV_W-1:0] crv;
        logic [1:0]       psel;
    } ccr_t;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import keyed_wdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  addr,
    input  logic        we,
    input  logic [31:0] wdata,
    input  logic        expired,
    output logic [31:0] rdata,
    output mode_t       mode,
    output ccr_t        ccr,
    output logic        kick,
    output logic        start
);

    typedef struct packed {
        mode_t mode;
        ccr_t  ccr;
    } regs_t;

    regs_t      st_d, st_q;
    logic       aligned;
    reg_sel_e   sel;
    logic [11:0] key;

    always_comb begin
        st_d    = st_q;
        kick    = 1'b0;
        start   = 1'b0;
        rdata   = '0;
        aligned = (addr[1:0] == 2'b00);
        sel     = reg_sel_e'(addr[3:2]);
        key     = wdata[23:12];
        if (we && aligned) begin
            case (sel)
                REG_MODE: if (key == MODE_KEY) begin
                    st_d.mode.en     = wdata[0];
                    st_d.mode.rst_en = wdata[1];
                    st_d.mode.irq_en = wdata[2];
                    st_d.mode.len    = wdata[5:4];
                    start            = wdata[0] && !st_q.mode.en;
                end
                REG_CCR: if (key == CCR_KEY) begin
                    st_d.ccr.crv  = wdata[13:2];
                    st_d.ccr.psel = wdata[1:0];
                end
                REG_KICK: kick = (wdata == RESTART_MAGIC);
                default: ;
            endcase
        end
        if (aligned) begin
            case (sel)
                REG_MODE: rdata = {26'd0, st_q.mode.len, 1'b0, st_q.mode.irq_en,
                                   st_q.mode.rst_en, st_q.mode.en};
                REG_CCR:  rdata = {18'd0, st_q.ccr.crv, st_q.ccr.psel};
                REG_STAT: rdata = {31'd0, expired};
                default:  rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode = st_q.mode;
    assign ccr  = st_q.ccr;

    // R2
    mode_key_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 4'h0 && wdata[23:12] != MODE_KEY) |=> $stable(st_q.mode));

    // R4
    ccr_key_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 4'h4 && wdata[23:12] != CCR_KEY) |=> $stable(st_q.ccr));

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int DIV0_LOG = 3,
    parameter int DIV1_LOG = 6,
    parameter int DIV2_LOG = 9,
    parameter int DIV3_LOG = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       clear,
    input  logic [1:0] psel,
    output logic       tick
);

    localparam int M01 = (DIV0_LOG > DIV1_LOG) ? DIV0_LOG : DIV1_LOG;
    localparam int M23 = (DIV2_LOG > DIV3_LOG) ? DIV2_LOG : DIV3_LOG;
    localparam int PW  = ((M01 > M23) ? M01 : M23) + 1;

    logic [PW-1:0] pcnt_d, pcnt_q;
    logic [PW-1:0] lim;

    always_comb begin
        case (psel)
            2'd0:    lim = PW'((64'd1 << DIV0_LOG) - 64'd1);
            2'd1:    lim = PW'((64'd1 << DIV1_LOG) - 64'd1);
            2'd2:    lim = PW'((64'd1 << DIV2_LOG) - 64'd1);
            default: lim = PW'((64'd1 << DIV3_LOG) - 64'd1);
        endcase
        tick = en && !clear && (pcnt_q == lim);
        if (!en || clear || tick) pcnt_d = '0;
        else                      pcnt_d = pcnt_q + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_d;
    end

    // R5
    tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pcnt_q == '0));

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import keyed_wdog_pkg::*;
#(
    parameter int COARSE_SHIFT = 12,
    localparam int CNT_W       = CRV_W + COARSE_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             reload,
    input  logic             tick,
    input  logic [CRV_W-1:0] crv,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        load_val = {crv, {COARSE_SHIFT{1'b1}}};
        expire   = en && tick && (cnt_q == CNT_W'(1));
        cnt_d    = cnt_q;
        if (reload)                           cnt_d = load_val;
        else if (en && tick && cnt_q != '0)   cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R6
    cnt_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |=> (cnt_q <= $past(cnt_q)));

    // R8
    expire_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt_q == '0));

    // R11
    frozen_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !reload) |=> $stable(cnt_q));

endmodule

// File: rtl/wdog_alarm.sv
module wdog_alarm (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       expire,
    input  logic       kick,
    input  logic       rst_en,
    input  logic       irq_en,
    input  logic [1:0] len,
    output logic       rst_o,
    output logic       irq_o,
    output logic       expired
);

    typedef struct packed {
        logic [4:0] pulse;
        logic       irq;
        logic       stat;
    } alarm_t;

    alarm_t al_d, al_q;

    always_comb begin
        al_d = al_q;
        if (expire && rst_en)      al_d.pulse = 5'd2 << len;
        else if (al_q.pulse != '0) al_d.pulse = al_q.pulse - 5'd1;
        if (expire) begin
            al_d.stat = 1'b1;
            if (irq_en) al_d.irq = 1'b1;
        end else if (kick) begin
            al_d.stat = 1'b0;
            al_d.irq  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) al_q <= '0;
        else        al_q <= al_d;
    end

    assign rst_o   = (al_q.pulse != '0);
    assign irq_o   = al_q.irq;
    assign expired = al_q.stat;

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (al_q.irq && !kick) |=> al_q.irq);

    // R9
    pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        al_q.pulse <= 5'd16);

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import keyed_wdog_pkg::*;
#(
    parameter int COARSE_SHIFT = 12,
    parameter int DIV0_LOG     = 3,
    parameter int DIV1_LOG     = 6,
    parameter int DIV2_LOG     = 9,
    parameter int DIV3_LOG     = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  bus_addr,
    input  logic        bus_we,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        wdt_rst_o,
    output logic        wdt_irq_o
);

    mode_t mode;
    ccr_t  ccr;
    logic  kick, start, reload, tick, expire, expired;

    assign reload = kick || start;

    wdog_regs u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
        .wdata(bus_wdata), .expired(expired), .rdata(bus_rdata),
        .mode(mode), .ccr(ccr), .kick(kick), .start(start)
    );

    wdog_prescaler #(
        .DIV0_LOG(DIV0_LOG), .DIV1_LOG(DIV1_LOG),
        .DIV2_LOG(DIV2_LOG), .DIV3_LOG(DIV3_LOG)
    ) u_pre (
        .clk(clk), .rst_n(rst_n), .en(mode.en), .clear(reload),
        .psel(ccr.psel), .tick(tick)
    );

    wdog_counter #(.COARSE_SHIFT(COARSE_SHIFT)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(mode.en), .reload(reload),
        .tick(tick), .crv(ccr.crv), .expire(expire)
    );

    wdog_alarm u_alarm (
        .clk(clk), .rst_n(rst_n), .expire(expire), .kick(kick),
        .rst_en(mode.rst_en), .irq_en(mode.irq_en), .len(mode.len),
        .rst_o(wdt_rst_o), .irq_o(wdt_irq_o), .expired(expired)
    );

endmodule

// File: tb/keyed_wdog_bench.sv
`timescale 1ns/1ps
module keyed_wdog_bench;

    localparam int SH = 2;
    localparam int DL [4] = '{1, 2, 3, 4};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_rst_o, wdt_irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    keyed_wdog #(.COARSE_SHIFT(SH), .DIV0_LOG(1), .DIV1_LOG(2),
                 .DIV2_LOG(3), .DIV3_LOG(4)) u_keyed_wdog (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_rst_o(wdt_rst_o), .wdt_irq_o(wdt_irq_o)
    );

    // behavioural reference state
    int m_en, m_rsten, m_irqen, m_len, m_crv, m_psel;
    int m_cnt, m_pcnt, m_pulse, m_irq, m_stat;

    always @(posedge clk) begin
        int wm, wc, rs, reload, tick, ex, div;
        if (!rst_n) begin
            m_en = 0; m_rsten = 0; m_irqen = 0; m_len = 0; m_crv = 0; m_psel = 0;
            m_cnt = 0; m_pcnt = 0; m_pulse = 0; m_irq = 0; m_stat = 0;
        end else begin
            wm = (bus_we && bus_addr == 4'h0 && bus_wdata[23:12] == 12'hABC) ? 1 : 0;
            wc = (bus_we && bus_addr == 4'h4 && bus_wdata[23:12] == 12'h920) ? 1 : 0;
            rs = (bus_we && bus_addr == 4'h8 && bus_wdata == 32'h1999) ? 1 : 0;
            reload = rs || (wm && bus_wdata[0] && !m_en);
            div = 1 << DL[m_psel];
            tick = (m_en && !reload && m_pcnt == div - 1) ? 1 : 0;
            ex = (tick && m_cnt == 1) ? 1 : 0;
            if (!m_en || reload || tick) m_pcnt = 0; else m_pcnt = m_pcnt + 1;
            if (reload) m_cnt = m_crv * (1 << SH) + (1 << SH) - 1;
            else if (tick && m_cnt != 0) m_cnt = m_cnt - 1;
            if (ex && m_rsten) m_pulse = 2 << m_len;
            else if (m_pulse > 0) m_pulse = m_pulse - 1;
            if (ex) begin m_stat = 1; if (m_irqen) m_irq = 1; end
            else if (rs) begin m_stat = 0; m_irq = 0; end
            if (wm) begin
                m_en = int'(bus_wdata[0]); m_rsten = int'(bus_wdata[1]);
                m_irqen = int'(bus_wdata[2]); m_len = int'(bus_wdata[5:4]);
            end
            if (wc) begin m_crv = int'(bus_wdata[13:2]); m_psel = int'(bus_wdata[1:0]); end
        end
    end

    // per-clock comparison of both outputs (R9, R10)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (wdt_rst_o !== (m_pulse != 0)) begin
                failures++;
                $display("FAIL R9 rst_o per-cycle actual=%0b expected=%0b", wdt_rst_o, m_pulse != 0);
            end
            checks++;
            if (wdt_irq_o !== (m_irq != 0)) begin
                failures++;
                $display("FAIL R10 irq_o per-cycle actual=%0b expected=%0b", wdt_irq_o, m_irq != 0);
            end
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, input string req, input logic [31:0] exp);
        bus_addr = a; bus_we = 1'b0;
        #1;
        chk(req, longint'(bus_rdata), longint'(exp));
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        while (!wdt_irq_o && n < 5000) begin @(posedge clk); n++; @(negedge clk); end
    endtask

    task automatic wait_rst(output int n);
        n = 0;
        while (!wdt_rst_o && n < 5000) begin @(posedge clk); n++; @(negedge clk); end
    endtask

    initial begin
        int n, w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(4'h0, "R1 mode", 32'h0);
        rd(4'h4, "R1 ccr", 32'h0);
        rd(4'h8, "R1 restart", 32'h0);
        rd(4'hC, "R1 status", 32'h0);
        chk("R1 outputs", {wdt_rst_o, wdt_irq_o}, 0);
        // R2 wrong key on mode
        wr(4'h0, 32'h00ABD037);
        rd(4'h0, "R2 bad mode key", 32'h0);
        wr(4'h1, 32'h00ABC037);
        rd(4'h0, "R1 misaligned write", 32'h0);
        // R4 wrong key then good key on counter control
        wr(4'h4, 32'h00921007);
        rd(4'h4, "R4 bad ccr key", 32'h0);
        wr(4'h4, 32'hFF920004);
        rd(4'h4, "R4 ccr readback", 32'h4);
        // R3 mode readback, irq path, select 0
        wr(4'h0, 32'hFFABC035);
        rd(4'h0, "R3 mode readback", 32'h35);
        wait_irq(n);
        chk("R6 R5 first expiry cycles psel0", n, 7 * 2);
        rd(4'hC, "R8 status set", 32'h1);
        // R7 wrong restart word
        wr(4'h8, 32'h00001998);
        wr(4'h8, 32'h10001999);
        rd(4'hC, "R7 status kept", 32'h1);
        chk("R7 irq kept", wdt_irq_o, 1);
        // R10 good restart clears, R6 reload timing on restart
        wr(4'h8, 32'h00001999);
        chk("R10 irq cleared", wdt_irq_o, 0);
        rd(4'hC, "R10 status cleared", 32'h0);
        wait_irq(n);
        chk("R6 restart reload cycles", n, 14);
        repeat (40) @(negedge clk);
        chk("R8 single expiry", wdt_irq_o, 1);
        // R9 and R5: reset pulse per length code, with psel = code
        for (int k = 0; k < 4; k++) begin
            wr(4'h0, 32'h00ABC000);
            wr(4'h8, 32'h00001999);
            wr(4'h4, 32'h00920004 | k);
            wr(4'h0, 32'h00ABC003 | (k << 4));
            wait_rst(n);
            chk($sformatf("R5 expiry cycles psel%0d", k), n, 7 * (1 << DL[k]));
            w = 0;
            while (wdt_rst_o && w < 100) begin w++; @(negedge clk); end
            chk($sformatf("R9 pulse width code%0d", k), w, 2 << k);
            chk("R10 irq off when disabled", wdt_irq_o, 0);
        end
        // R11 disabled watchdog does not expire
        wr(4'h0, 32'h00ABC000);
        wr(4'h8, 32'h00001999);
        wr(4'h4, 32'h00920004);
        wr(4'h0, 32'h00ABC005);
        repeat (6) @(negedge clk);
        wr(4'h0, 32'h00ABC004);
        repeat (100) @(negedge clk);
        chk("R11 no irq while off", wdt_irq_o, 0);
        rd(4'hC, "R11 no status while off", 32'h0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule